// File: doc/BRIEF.md
# Offset-Range Modulo Counter

A synchronous binary counter that cycles through a contiguous window of codes that does not start at zero. The counter has a fixed parallel-load value (the preset) and a terminal value. When counting is enabled and the state equals the terminal value, the next clock edge reloads the preset through the synchronous load path. With the default parameters, the state therefore repeats 9, 10, 11, 12, 13, 14, 9, and so on. This is a modulo-6 sequence that sits in codes 9 to 14.

Reset is synchronous and active high. On reset the counter takes the preset through the same load path, so every state change happens on a clock edge and no short transient code can appear. A carry-out flag reports the all-ones state. When the terminal value is itself all ones, the terminal detector reuses that all-ones test.

Top module: `offset_mod_counter`

## Requirements
- R1: While `rst` is 1 at a rising edge, `count_q` becomes PRESET (default 9) after that edge, whatever `cnt_en` is.
- R2: With `rst` 0 and `cnt_en` 0, `count_q` keeps its value across the edge, including when it equals TERMINAL.
- R3: With `rst` 0, `cnt_en` 1 and `count_q` not equal to TERMINAL, `count_q` becomes its old value plus one.
- R4: With `rst` 0, `cnt_en` 1 and `count_q` equal to TERMINAL (default 14), `count_q` becomes PRESET on the next edge.
- R5: After reset, `count_q` only ever shows codes from PRESET to TERMINAL inclusive, and no other code appears for even one cycle.
- R6: `carry_out` is 1 exactly in the cycles where every bit of `count_q` is 1.
- R7: When TERMINAL is all ones (15 for 4 bits), the counter still wraps to PRESET after that state, and `carry_out` is 1 for that one state in each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; loads the preset |
| cnt_en | input | 1 | Count enable; 0 holds the state |
| count_q | output | WIDTH | Registered counter state |
| carry_out | output | 1 | Registered flag, 1 when the state is all ones |

## Verification
The assertions check on every cycle the following: the per-edge transitions for reset, hold, increment and wrap; that the state stays inside the window; and that the carry flag agrees with the state. Some behaviour shows only over time, and only the bench scenarios can demonstrate it. This covers the full six-state period under continuous enable, holding at the terminal value across several idle cycles, and reset overriding an active enable mid-sequence. It also covers the all-ones terminal variant, which a second instance exercises together with a carry pulse once per period.

// File: rtl/omc_pkg.sv
package omc_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2
  } omc_act_e;
endpackage

// File: rtl/omc_term_detect.sv
module omc_term_detect #(
  parameter int WIDTH    = 4,
  parameter int TERMINAL = 14
) (
  input  logic [WIDTH-1:0] state_q,
  output logic             term_hit
);
  localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERMINAL);
  localparam logic [WIDTH-1:0] ONES_V = '1;

  generate
    if (TERM_V == ONES_V) begin : g_all_ones
      // terminal equals the carry condition: reuse the AND reduction
      assign term_hit = &state_q;
    end else begin : g_compare
      assign term_hit = (state_q == TERM_V);
    end
  endgenerate
endmodule

// File: rtl/omc_action_sel.sv
module omc_action_sel
  import omc_pkg::*;
(
  input  logic     rst,
  input  logic     cnt_en,
  input  logic     term_hit,
  output omc_act_e act
);
  always_comb begin
    if (rst)                   act = ACT_LOAD;
    else if (cnt_en && term_hit) act = ACT_LOAD;
    else if (cnt_en)           act = ACT_COUNT;
    else                       act = ACT_HOLD;
  end
endmodule

// File: rtl/omc_state_reg.sv
module omc_state_reg
  import omc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter int PRESET = 9
) (
  input  logic             clk,
  input  omc_act_e         act,
  output logic [WIDTH-1:0] state_q,
  output logic             carry_q
);
  localparam logic [WIDTH-1:0] PRESET_V = WIDTH'(PRESET);
  localparam logic [WIDTH-1:0] ONE_V    = WIDTH'(1);

  logic [WIDTH-1:0] inc_v;
  assign inc_v = state_q + ONE_V;

  always_ff @(posedge clk) begin
    case (act)
      ACT_LOAD: begin
        state_q <= PRESET_V;
        carry_q <= &PRESET_V;
      end
      ACT_COUNT: begin
        state_q <= inc_v;
        carry_q <= &inc_v;
      end
      default: begin
        state_q <= state_q;
        carry_q <= carry_q;
      end
    endcase
  end
endmodule

// File: rtl/offset_mod_counter.sv
module offset_mod_counter
  import omc_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int PRESET   = 9,
  parameter int TERMINAL = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  output logic [WIDTH-1:0] count_q,
  output logic             carry_out
);
  logic     term_hit;
  omc_act_e act;

  generate
    if (PRESET > TERMINAL || TERMINAL >= (1 << WIDTH)) begin : g_bad_cfg
      $error("offset_mod_counter: PRESET/TERMINAL outside counter range");
    end
  endgenerate

  omc_term_detect #(.WIDTH(WIDTH), .TERMINAL(TERMINAL)) u_detect (
    .state_q  (count_q),
    .term_hit (term_hit)
  );

  omc_action_sel u_sel (
    .rst      (rst),
    .cnt_en   (cnt_en),
    .term_hit (term_hit),
    .act      (act)
  );

  omc_state_reg #(.WIDTH(WIDTH), .PRESET(PRESET)) u_reg (
    .clk     (clk),
    .act     (act),
    .state_q (count_q),
    .carry_q (carry_out)
  );
endmodule

// File: rtl/omc_checker.sv
module omc_checker #(
  parameter int WIDTH    = 4,
  parameter int PRESET   = 9,
  parameter int TERMINAL = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic [WIDTH-1:0] count_q,
  input logic             carry_out
);
  localparam logic [WIDTH-1:0] PRESET_V = WIDTH'(PRESET);
  localparam logic [WIDTH-1:0] TERM_V   = WIDTH'(TERMINAL);
  localparam logic [WIDTH-1:0] ONE_V    = WIDTH'(1);

  AST_RESET_PRESET: assert property (@(posedge clk) rst |=> count_q == PRESET_V); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !cnt_en |=> $stable(count_q)); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst) (cnt_en && count_q != TERM_V) |=> count_q == $past(count_q) + ONE_V); // R3
  AST_WRAP_PRESET: assert property (@(posedge clk) disable iff (rst) (cnt_en && count_q == TERM_V) |=> count_q == PRESET_V); // R4
  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst) (count_q >= PRESET_V) && (count_q <= TERM_V)); // R5
  AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (rst) carry_out == (&count_q)); // R6
endmodule

bind offset_mod_counter omc_checker #(
  .WIDTH(WIDTH), .PRESET(PRESET), .TERMINAL(TERMINAL)
) u_omc_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .count_q(count_q), .carry_out(carry_out)
);

// File: tb/offset_mod_counter_bench.sv
module offset_mod_counter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_en = 1'b0;
  logic [3:0] cnt_a, cnt_b;
  logic co_a, co_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [3:0] exp_a, exp_b;
  bit valid = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  offset_mod_counter u_offset_mod_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .count_q(cnt_a), .carry_out(co_a)
  );

  offset_mod_counter #(.WIDTH(4), .PRESET(10), .TERMINAL(15)) u_offset_mod_counter_t15 (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .count_q(cnt_b), .carry_out(co_b)
  );

  function automatic logic [3:0] nxt(input logic [3:0] cur, input logic en, input logic r,
                                     input int pre, input int term);
    if (r) return 4'(pre);
    if (!en) return cur;
    if (int'(cur) == term) return 4'(pre);
    return cur + 4'd1;
  endfunction

  function automatic string pick_tag(input logic [3:0] cur, input logic en, input logic r,
                                     input int term);
    if (r) return "R1";
    if (!en) return "R2";
    if (int'(cur) == term) return "R4";
    return "R3";
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input logic en, input logic r);
    string ta, tb;
    @(negedge clk);
    cnt_en = en;
    rst = r;
    ta = pick_tag(exp_a, en, r, 14);
    tb = pick_tag(exp_b, en, r, 15);
    if (r) valid = 1'b1;
    exp_a = nxt(exp_a, en, r, 9, 14);
    exp_b = nxt(exp_b, en, r, 10, 15);
    @(posedge clk);
    #1;
    if (valid) begin
      chk(ta, int'(cnt_a), int'(exp_a));
      chk({ta, "_t15 R7"}, int'(cnt_b), int'(exp_b));
      chk("R5 window", int'(cnt_a >= 4'd9 && cnt_a <= 4'd14), 1);
      chk("R6 carry", int'(co_a), int'(&exp_a));
      chk("R7 carry_t15", int'(co_b), int'(&exp_b));
    end
  endtask

  initial begin
    exp_a = '0;
    exp_b = '0;
    // R1: reset loads the preset
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    // R3 R4 R5 R6 R7: continuous counting over several periods
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0);
    // R2: park on the terminal value with enable low
    for (int i = 0; i < 6 && exp_a != 4'd14; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    // mixed enable pattern
    for (int i = 0; i < 40; i++) step(i % 3 != 0, 1'b0);
    // R1: reset overrides an active enable mid-sequence
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule